// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in-first-out buffer with a write port and a read port in two unrelated clock domains. Either clock may be the faster one, and pushes and pops may take place at the same time. The storage is an inferred dual-port RAM of `2**AW` words of `DW` bits (18 by default). The write and read pointers cross between the domains as Gray codes through flop synchronisers. Each flag is computed in the domain that reacts to it. Write-side flags are `wr_block`, `half_full` and `almost_full`. Read-side flags are `rd_block` and `almost_empty`.

Two read timings are available, selected at master reset. In the standard timing, `rd_block` means empty, and each accepted read loads the next word into `dout`. In the fall-through timing, `rd_block` low means a word is already waiting on `dout`, and `ren` consumes it. The read register then acts as one extra storage slot. The almost-empty and almost-full offsets start at one of two preset values. They can be reloaded through a bit-serial path or as parallel words on `din`. A partial reset empties the buffer but keeps the offsets and the timing choice. A retransmit pulse rewinds the read side to the first location written since the last reset.

Top module: `xclk_flag_fifo`

## Requirements
- R1: Words are read out in the order they were written, with writes and reads running at the same time on independent clocks.
- R2: In standard timing, `rd_block` is high while nothing is stored. A read (`ren` high and `rd_block` low at an `rclk` edge) puts the oldest word on `dout` at that edge. A read while `rd_block` is high is ignored and `dout` keeps its value.
- R3: `wr_block` is high when the RAM holds `2**AW` words. A write while `wr_block` is high is ignored.
- R4: In fall-through timing, the first word appears on `dout` with `rd_block` low without any `ren`. `dout` holds while `ren` is low. Total capacity is `2**AW + 1` words, so `wr_block` rises one word later than in standard timing.
- R5: `half_full` is high when the write-side count exceeds `2**AW / 2`.
- R6: `almost_empty` is high when the read-side count is at most the empty offset. `almost_full` is high when the write-side count is at least `2**AW` minus the full offset. The read-side count includes the word held on `dout` in fall-through timing.
- R7: Master reset (`mrst`) empties the buffer and latches `fwft_cfg` as the timing choice (0 standard, 1 fall-through). It sets both offsets to `DEF_LO` when `dflt_sel` is 0, or to `DEF_HI` when `dflt_sel` is 1.
- R8: A write with `ld` high stores no data. It loads `din[AW-1:0]` into the empty offset, then the next such write loads the full offset, alternating. The sequence restarts at the empty offset after either reset.
- R9: With `sen` high, each `wclk` edge shifts `sdin` into bit 0 of the concatenation {full offset, empty offset}. The full offset is the upper AW bits, so the first bit sent ends up as the full offset's MSB. `sen` takes priority over `ld` and stores no data.
- R10: Partial reset (`prst`) empties the buffer but keeps both offsets and the timing choice.
- R11: A `rt` pulse at an `rclk` edge rewinds the read pointer to location 0. In standard timing the next read returns the first word written since reset. In fall-through timing that word reappears on `dout` within two `rclk` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst | input | 1 | Master reset, synchronous, held over several cycles of both clocks |
| prst | input | 1 | Partial reset, synchronous, held over several cycles of both clocks |
| fwft_cfg | input | 1 | Timing choice latched at master reset |
| dflt_sel | input | 1 | Default offset choice latched at master reset |
| wen | input | 1 | Write enable (wclk) |
| din | input | DW | Write data or parallel offset word |
| ld | input | 1 | Parallel offset load select |
| sen | input | 1 | Serial offset shift enable |
| sdin | input | 1 | Serial offset bit |
| ren | input | 1 | Read enable (rclk) |
| rt | input | 1 | Retransmit pulse (rclk) |
| dout | output | DW | Read data register |
| rd_block | output | 1 | Standard: empty; fall-through: no word presented |
| wr_block | output | 1 | Full (input not ready) |
| half_full | output | 1 | Write-side count above half |
| almost_empty | output | 1 | Read-side count at or below empty offset |
| almost_full | output | 1 | Write-side count at or above full threshold |

## Verification
The case most likely to break is a push and a pop landing together near a boundary. In fall-through timing this can mean a refill of the output register on the same `rclk` edge that consumes it, while a write is arriving behind the synchroniser. Concurrent random traffic provokes it in both timings: about 60 % write enables on the faster clock against 50 % read enables, which drives the buffer into both full and empty repeatedly. Every word on `dout` is compared with a queue model at the cycle the bench predicts from its own view of `rd_block`. Any lost, duplicated or reordered word shows up as a mismatch.

// File: rtl/xff_pkg.sv
package xff_pkg;

  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } xff_mode_e;

  function automatic logic [31:0] bin2gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray2bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

endpackage

// File: rtl/xff_sync.sv
module xff_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/xff_ram.sv
module xff_ram #(
  parameter int DW = 18,
  parameter int AW = 8
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/xff_wr_ctl.sv
module xff_wr_ctl #(
  parameter int AW     = 8,
  parameter int DEF_LO = 7,
  parameter int DEF_HI = 63
) (
  input  logic          clk,
  input  logic          mrst,
  input  logic          prst,
  input  logic          dflt_sel,
  input  logic          wen,
  input  logic [AW-1:0] ld_word,
  input  logic          ld,
  input  logic          sen,
  input  logic          sdin,
  input  logic [AW:0]   rptr_g_sync,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [AW:0]   wptr_g,
  output logic [AW:0]   wptr_bin,
  output logic [AW-1:0] ae_off,
  output logic          wr_block,
  output logic          half_full,
  output logic          almost_full
);

  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
  localparam logic [PW-1:0] HALF_P  = PW'(DEPTH / 2);
  localparam logic [AW-1:0] OFF_LO  = AW'(DEF_LO);
  localparam logic [AW-1:0] OFF_HI  = AW'(DEF_HI);

  logic            rst;
  logic [PW-1:0]   rbin;
  logic [PW-1:0]   cnt;
  logic            full;
  logic            do_wr;
  logic [PW-1:0]   wptr_nxt;
  logic [AW-1:0]   af_off;
  logic            psel;
  logic [2*AW-1:0] off_shift;

  assign rst      = mrst | prst;
  assign rbin     = PW'(xff_pkg::gray2bin(32'(rptr_g_sync)));
  assign cnt      = wptr_bin - rbin;
  assign full     = (cnt == DEPTH_P);
  assign do_wr    = wen & ~ld & ~sen & ~full;
  assign wptr_nxt = wptr_bin + PW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr_bin <= '0;
      wptr_g   <= '0;
    end else if (do_wr) begin
      wptr_bin <= wptr_nxt;
      wptr_g   <= PW'(xff_pkg::bin2gray(32'(wptr_nxt)));
    end
  end

  assign off_shift = {af_off[AW-2:0], ae_off, sdin};

  always_ff @(posedge clk) begin
    if (mrst) begin
      ae_off <= dflt_sel ? OFF_HI : OFF_LO;
      af_off <= dflt_sel ? OFF_HI : OFF_LO;
      psel   <= 1'b0;
    end else if (prst) begin
      psel   <= 1'b0;
    end else if (sen) begin
      af_off <= off_shift[2*AW-1:AW];
      ae_off <= off_shift[AW-1:0];
    end else if (ld && wen) begin
      if (!psel) ae_off <= ld_word;
      else       af_off <= ld_word;
      psel <= ~psel;
    end
  end

  assign mem_we      = do_wr;
  assign mem_waddr   = wptr_bin[AW-1:0];
  assign wr_block    = full;
  assign half_full   = (cnt > HALF_P);
  assign almost_full = (cnt >= (DEPTH_P - {1'b0, af_off}));

endmodule

// File: rtl/xff_rd_ctl.sv
module xff_rd_ctl #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          mrst,
  input  logic          prst,
  input  logic          fwft_cfg,
  input  logic          ren,
  input  logic          rt,
  input  logic [AW:0]   wptr_g_sync,
  input  logic [AW-1:0] ae_off,
  output logic          mem_re,
  output logic [AW-1:0] mem_raddr,
  output logic [AW:0]   rptr_g,
  output logic [AW:0]   rptr_bin,
  output logic          fwft_mode,
  output logic          rd_block,
  output logic          almost_empty
);

  import xff_pkg::*;

  localparam int PW = AW + 1;

  logic          rst;
  xff_mode_e     mode_q;
  logic          dvalid;
  logic [PW-1:0] wbin;
  logic          avail;
  logic          fetch;
  logic [PW-1:0] rptr_nxt;
  logic [PW-1:0] cnt_r;

  assign rst       = mrst | prst;
  assign fwft_mode = (mode_q == MODE_FWFT);
  assign wbin      = PW'(gray2bin(32'(wptr_g_sync)));
  assign avail     = (wbin != rptr_bin);
  assign rptr_nxt  = rptr_bin + PW'(1);

  always_comb begin
    if (rt)             fetch = 1'b0;
    else if (fwft_mode) fetch = avail & (~dvalid | ren);
    else                fetch = avail & ren;
  end

  always_ff @(posedge clk) begin
    if (mrst) mode_q <= xff_mode_e'(fwft_cfg);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rptr_bin <= '0;
      rptr_g   <= '0;
      dvalid   <= 1'b0;
    end else if (rt) begin
      rptr_bin <= '0;
      rptr_g   <= '0;
      dvalid   <= 1'b0;
    end else begin
      if (fetch) begin
        rptr_bin <= rptr_nxt;
        rptr_g   <= PW'(bin2gray(32'(rptr_nxt)));
      end
      if (fwft_mode) begin
        if (fetch)    dvalid <= 1'b1;
        else if (ren) dvalid <= 1'b0;
      end
    end
  end

  assign cnt_r        = wbin - rptr_bin + PW'(fwft_mode & dvalid);
  assign mem_re       = fetch;
  assign mem_raddr    = rptr_bin[AW-1:0];
  assign rd_block     = fwft_mode ? ~dvalid : ~avail;
  assign almost_empty = (cnt_r <= {1'b0, ae_off});

endmodule

// File: rtl/xclk_flag_fifo.sv
module xclk_flag_fifo #(
  parameter int DW          = 18,
  parameter int AW          = 8,
  parameter int DEF_LO      = 7,
  parameter int DEF_HI      = 63,
  parameter int SYNC_STAGES = 2
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          mrst,
  input  logic          prst,
  input  logic          fwft_cfg,
  input  logic          dflt_sel,
  input  logic          wen,
  input  logic [DW-1:0] din,
  input  logic          ld,
  input  logic          sen,
  input  logic          sdin,
  input  logic          ren,
  input  logic          rt,
  output logic [DW-1:0] dout,
  output logic          rd_block,
  output logic          wr_block,
  output logic          half_full,
  output logic          almost_empty,
  output logic          almost_full
);

  localparam int PW = AW + 1;

  logic          wrst, rrst;
  logic [PW-1:0] wptr_g, wptr_bin, wptr_g_rs;
  logic [PW-1:0] rptr_g, rptr_bin, rptr_g_ws;
  logic          mem_we, mem_re;
  logic [AW-1:0] mem_waddr, mem_raddr;
  logic [AW-1:0] ae_off;
  logic          fwft_mode;

  assign wrst = mrst | prst;
  assign rrst = mrst | prst;

  xff_wr_ctl #(.AW(AW), .DEF_LO(DEF_LO), .DEF_HI(DEF_HI)) u_wr (
    .clk(wclk), .mrst(mrst), .prst(prst), .dflt_sel(dflt_sel),
    .wen(wen), .ld_word(din[AW-1:0]), .ld(ld), .sen(sen), .sdin(sdin),
    .rptr_g_sync(rptr_g_ws),
    .mem_we(mem_we), .mem_waddr(mem_waddr),
    .wptr_g(wptr_g), .wptr_bin(wptr_bin), .ae_off(ae_off),
    .wr_block(wr_block), .half_full(half_full), .almost_full(almost_full)
  );

  xff_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_r2w (
    .clk(wclk), .rst(wrst), .d(rptr_g), .q(rptr_g_ws)
  );

  xff_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_w2r (
    .clk(rclk), .rst(rrst), .d(wptr_g), .q(wptr_g_rs)
  );

  xff_rd_ctl #(.AW(AW)) u_rd (
    .clk(rclk), .mrst(mrst), .prst(prst), .fwft_cfg(fwft_cfg),
    .ren(ren), .rt(rt), .wptr_g_sync(wptr_g_rs), .ae_off(ae_off),
    .mem_re(mem_re), .mem_raddr(mem_raddr),
    .rptr_g(rptr_g), .rptr_bin(rptr_bin), .fwft_mode(fwft_mode),
    .rd_block(rd_block), .almost_empty(almost_empty)
  );

  xff_ram #(.DW(DW), .AW(AW)) u_ram (
    .wclk(wclk), .we(mem_we), .waddr(mem_waddr), .wdata(din),
    .rclk(rclk), .re(mem_re), .raddr(mem_raddr), .rdata(dout)
  );

endmodule

// File: rtl/xff_chk.sv
module xff_chk #(
  parameter int DW = 18,
  parameter int AW = 8
) (
  input logic          wclk,
  input logic          rclk,
  input logic          mrst,
  input logic          prst,
  input logic          wen,
  input logic          ren,
  input logic          rt,
  input logic          wr_block,
  input logic          rd_block,
  input logic          almost_full,
  input logic [DW-1:0] dout,
  input logic [AW:0]   wptr_bin,
  input logic [AW:0]   rptr_bin,
  input logic          fwft_mode
);

  // R3
  no_overflow_chk: assert property (@(posedge wclk) disable iff (mrst || prst)
    (wen && wr_block) |=> $stable(wptr_bin));

  // R2
  no_underflow_chk: assert property (@(posedge rclk) disable iff (mrst || prst)
    (ren && rd_block && !rt && !fwft_mode) |=> $stable(rptr_bin));

  // R6
  full_af_chk: assert property (@(posedge wclk) disable iff (mrst || prst)
    wr_block |-> almost_full);

  // R11
  rt_rewind_chk: assert property (@(posedge rclk) disable iff (mrst || prst)
    rt |=> (rptr_bin == '0));

  // R4
  fwft_hold_chk: assert property (@(posedge rclk) disable iff (mrst || prst)
    (fwft_mode && !rd_block && !ren && !rt) |=> (!rd_block && $stable(dout)));

  // R1
  wptr_step_chk: assert property (@(posedge wclk) disable iff (mrst || prst)
    1'b1 |=> (wptr_bin == $past(wptr_bin)) || (wptr_bin == $past(wptr_bin) + 1'b1));

endmodule

bind xclk_flag_fifo xff_chk #(.DW(DW), .AW(AW)) u_chk (
  .wclk(wclk), .rclk(rclk), .mrst(mrst), .prst(prst),
  .wen(wen), .ren(ren), .rt(rt),
  .wr_block(wr_block), .rd_block(rd_block), .almost_full(almost_full),
  .dout(dout), .wptr_bin(wptr_bin), .rptr_bin(rptr_bin), .fwft_mode(fwft_mode)
);

// File: tb/xclk_flag_fifo_tb.sv
module xclk_flag_fifo_tb;

  localparam int DW = 18;
  localparam int AW = 5;
  localparam int DEPTH = 1 << AW;
  localparam int DLO = 3;
  localparam int DHI = 9;

  logic wclk = 1'b0, rclk = 1'b0;
  logic mrst = 1'b0, prst = 1'b0, fwft_cfg = 1'b0, dflt_sel = 1'b0;
  logic wen = 1'b0, ld = 1'b0, sen = 1'b0, sdin = 1'b0, ren = 1'b0, rt = 1'b0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic rd_block, wr_block, half_full, almost_empty, almost_full;

  always #4 wclk = ~wclk;
  always #7 rclk = ~rclk;

  xclk_flag_fifo #(.DW(DW), .AW(AW), .DEF_LO(DLO), .DEF_HI(DHI)) u_dut (
    .wclk(wclk), .rclk(rclk), .mrst(mrst), .prst(prst), .fwft_cfg(fwft_cfg),
    .dflt_sel(dflt_sel), .wen(wen), .din(din), .ld(ld), .sen(sen), .sdin(sdin),
    .ren(ren), .rt(rt), .dout(dout), .rd_block(rd_block), .wr_block(wr_block),
    .half_full(half_full), .almost_empty(almost_empty), .almost_full(almost_full)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [DW-1:0] q[$];

  task automatic chk_eq(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #1500000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  task automatic settle();
    repeat (10) @(negedge wclk);
    @(negedge rclk);
  endtask

  task automatic do_mrst(bit mode, bit sel);
    @(negedge wclk);
    fwft_cfg = mode; dflt_sel = sel; mrst = 1'b1;
    wen = 0; ren = 0; ld = 0; sen = 0; rt = 0;
    repeat (8) @(negedge wclk);
    mrst = 1'b0;
    settle();
  endtask

  task automatic do_prst(bit mode);
    @(negedge wclk);
    fwft_cfg = mode; prst = 1'b1;
    repeat (8) @(negedge wclk);
    prst = 1'b0;
    settle();
  endtask

  task automatic wr_n(int base, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge wclk);
      wen = 1'b1; din = DW'(base + i);
    end
    @(negedge wclk);
    wen = 1'b0;
  endtask

  task automatic rd_std(output logic [DW-1:0] d);
    @(negedge rclk); ren = 1'b1;
    @(negedge rclk); ren = 1'b0;
    d = dout;
  endtask

  task automatic pop_fwft(output logic [DW-1:0] d);
    @(negedge rclk); d = dout; ren = 1'b1;
    @(negedge rclk); ren = 1'b0;
  endtask

  task automatic pulse_rt();
    @(negedge rclk); rt = 1'b1;
    @(negedge rclk); rt = 1'b0;
  endtask

  task automatic run_random(bit mode, int n);
    bit wdone = 1'b0;
    logic [DW-1:0] exp_d = '0;
    bit pend = 1'b0;
    q.delete();
    do_mrst(mode, 1'b0);
    fork
      begin
        for (int i = 0; i < n; i++) begin
          @(negedge wclk);
          wen = ($urandom_range(99) < 60);
          din = DW'($urandom);
          if (wen && !wr_block) q.push_back(din);
        end
        @(negedge wclk);
        wen = 1'b0;
        wdone = 1'b1;
      end
      begin
        while (!(wdone && q.size() == 0 && !pend)) begin
          @(negedge rclk);
          if (!mode) begin
            if (pend) chk_eq("R1", "random std data", int'(dout), int'(exp_d));
            ren = ($urandom_range(99) < 50);
            pend = 1'b0;
            if (ren && !rd_block) begin
              if (q.size() == 0) chk_eq("R2", "read with model empty", 1, 0);
              else begin exp_d = q.pop_front(); pend = 1'b1; end
            end
          end else begin
            ren = ($urandom_range(99) < 50);
            if (!rd_block) begin
              if (q.size() == 0) chk_eq("R4", "word shown with model empty", 1, 0);
              else begin
                chk_eq("R1", "random fwft data", int'(dout), int'(q[0]));
                if (ren) void'(q.pop_front());
              end
            end
          end
        end
        ren = 1'b0;
      end
    join
  endtask

  initial begin
    logic [DW-1:0] d;
    logic [2*AW-1:0] ser;
    void'($urandom(32'd2024));

    // Reset state, standard timing, low defaults
    do_mrst(1'b0, 1'b0);
    chk_eq("R7", "rd_block after mrst", rd_block, 1);
    chk_eq("R7", "wr_block after mrst", wr_block, 0);
    chk_eq("R7", "almost_empty after mrst", almost_empty, 1);
    chk_eq("R7", "half_full after mrst", half_full, 0);
    chk_eq("R7", "almost_full after mrst", almost_full, 0);

    wr_n(100, 3); settle();
    chk_eq("R6", "almost_empty at 3 words", almost_empty, 1);
    chk_eq("R2", "rd_block with data", rd_block, 0);
    wr_n(103, 1); settle();
    chk_eq("R7", "almost_empty at 4 words, low default", almost_empty, 0);
    wr_n(104, 12); settle();
    chk_eq("R5", "half_full at 16", half_full, 0);
    wr_n(116, 1); settle();
    chk_eq("R5", "half_full at 17", half_full, 1);
    wr_n(117, 11); settle();
    chk_eq("R6", "almost_full at 28", almost_full, 0);
    wr_n(128, 1); settle();
    chk_eq("R6", "almost_full at 29", almost_full, 1);
    wr_n(129, 3); settle();
    chk_eq("R3", "wr_block at capacity", wr_block, 1);
    wr_n(18'h3ffff, 1); settle();
    for (int i = 0; i < DEPTH; i++) begin
      rd_std(d);
      chk_eq("R1", "std drain order", int'(d), 100 + i);
    end
    settle();
    chk_eq("R2", "rd_block after drain", rd_block, 1);
    chk_eq("R3", "wr_block after drain", wr_block, 0);
    rd_std(d);
    chk_eq("R2", "dout held on empty read", int'(d), 100 + DEPTH - 1);

    // High defaults
    do_mrst(1'b0, 1'b1);
    wr_n(0, 9); settle();
    chk_eq("R7", "almost_empty at 9, high default", almost_empty, 1);
    wr_n(9, 1); settle();
    chk_eq("R7", "almost_empty at 10, high default", almost_empty, 0);
    wr_n(10, 12); settle();
    chk_eq("R7", "almost_full at 22, high default", almost_full, 0);
    wr_n(22, 1); settle();
    chk_eq("R7", "almost_full at 23, high default", almost_full, 1);

    // Parallel load: empty offset 5, full offset 6
    do_mrst(1'b0, 1'b0);
    @(negedge wclk); ld = 1'b1;
    wr_n(5, 1);
    wr_n(6, 1);
    @(negedge wclk); ld = 1'b0;
    settle();
    chk_eq("R8", "no data stored by offset load", rd_block, 1);
    wr_n(0, 5); settle();
    chk_eq("R8", "almost_empty at 5, offset 5", almost_empty, 1);
    wr_n(5, 1); settle();
    chk_eq("R8", "almost_empty at 6, offset 5", almost_empty, 0);
    wr_n(6, 19); settle();
    chk_eq("R8", "almost_full at 25, offset 6", almost_full, 0);
    wr_n(25, 1); settle();
    chk_eq("R8", "almost_full at 26, offset 6", almost_full, 1);

    // Partial reset keeps offsets
    do_prst(1'b0);
    chk_eq("R10", "rd_block after prst", rd_block, 1);
    chk_eq("R10", "wr_block after prst", wr_block, 0);
    wr_n(0, 4); settle();
    chk_eq("R10", "almost_empty at 4 keeps offset 5", almost_empty, 1);
    wr_n(4, 23); settle();
    chk_eq("R10", "almost_full at 27 keeps offset 6", almost_full, 1);

    // Serial load: full offset 10, empty offset 7
    do_mrst(1'b0, 1'b0);
    ser = {AW'(10), AW'(7)};
    for (int i = 2*AW-1; i >= 0; i--) begin
      @(negedge wclk); sen = 1'b1; sdin = ser[i]; ld = 1'b1; wen = 1'b1;
    end
    @(negedge wclk); sen = 1'b0; ld = 1'b0; wen = 1'b0;
    settle();
    chk_eq("R9", "no data stored by serial load", rd_block, 1);
    wr_n(0, 7); settle();
    chk_eq("R9", "almost_empty at 7, offset 7", almost_empty, 1);
    wr_n(7, 1); settle();
    chk_eq("R9", "almost_empty at 8, offset 7", almost_empty, 0);
    wr_n(8, 13); settle();
    chk_eq("R9", "almost_full at 21, offset 10", almost_full, 0);
    wr_n(21, 1); settle();
    chk_eq("R9", "almost_full at 22, offset 10", almost_full, 1);

    // Retransmit, standard timing
    do_mrst(1'b0, 1'b0);
    wr_n(200, 6); settle();
    for (int i = 0; i < 6; i++) begin
      rd_std(d);
      chk_eq("R11", "first pass", int'(d), 200 + i);
    end
    pulse_rt(); settle();
    chk_eq("R11", "rd_block after rewind", rd_block, 0);
    for (int i = 0; i < 6; i++) begin
      rd_std(d);
      chk_eq("R11", "second pass", int'(d), 200 + i);
    end

    // Fall-through timing
    do_mrst(1'b1, 1'b0);
    chk_eq("R4", "rd_block after fwft mrst", rd_block, 1);
    wr_n(300, 1); settle();
    chk_eq("R4", "first word shown without read", rd_block, 0);
    chk_eq("R4", "first word value", int'(dout), 300);
    settle();
    chk_eq("R4", "word held without read", int'(dout), 300);
    wr_n(301, DEPTH - 1); settle();
    chk_eq("R4", "wr_block with 32 total", wr_block, 0);
    wr_n(301 + DEPTH - 1, 1); settle();
    chk_eq("R4", "wr_block with 33 total", wr_block, 1);
    chk_eq("R6", "almost_empty with 33 total", almost_empty, 0);
    wr_n(18'h3ffff, 1); settle();
    for (int i = 0; i < DEPTH + 1; i++) begin
      pop_fwft(d);
      chk_eq("R4", "fwft drain order", int'(d), 300 + i);
    end
    settle();
    chk_eq("R4", "rd_block after fwft drain", rd_block, 1);

    // Retransmit, fall-through timing, then partial reset keeps mode
    do_mrst(1'b1, 1'b0);
    wr_n(400, 4); settle();
    pop_fwft(d);
    pop_fwft(d);
    chk_eq("R4", "second fwft word", int'(d), 401);
    pulse_rt(); settle();
    chk_eq("R11", "fwft word 0 after rewind", int'(dout), 400);
    chk_eq("R11", "fwft ready after rewind", rd_block, 0);
    do_prst(1'b0);
    wr_n(500, 1); settle();
    chk_eq("R10", "fwft kept after prst", rd_block, 0);
    chk_eq("R10", "word shown after prst", int'(dout), 500);

    // Concurrent random traffic
    run_random(1'b0, 1500);
    run_random(1'b1, 1500);

    done = 1'b1;
    summary();
  end

endmodule